// File: doc/BRIEF.md
# Management Interrupt Entry Sequencer

This block sits in the bus interface of a processor. System logic drives an active-low management interrupt request at any time, with no relation to the bus clock. The block brings that request into the bus clock domain. It then decides, at each response-status strobe of a bus transaction, whether the request was seen early enough to be taken at that transaction. When the request is taken, the block walks through a fixed entry sequence. It pulses a state-save request toward the core and waits for the save to finish. It then raises an acknowledge bus transaction and holds it until the bus side reports completion. Finally it redirects execution to the handler and stays in management mode until a resume pulse arrives.

The block also watches the release of reset. If the request is active at that moment, it raises an output high-impedance enable for the pad ring, and that enable stays set until the next reset. State-save storage, the acknowledge encoding and the handler fetch are outside the block. Each appears only as a request/done handshake.

States:
- `ST_IDLE`: waits for an accepted request.
- `ST_SAVE_REQ`: one-cycle save pulse.
- `ST_SAVE_WAIT`: waits for `save_done`.
- `ST_ACK`: acknowledge held until `ack_done`.
- `ST_ENTER`: one-cycle handler redirect.
- `ST_MGMT`: management mode until `resume`.

Transitions:
- IDLE→SAVE_REQ on accept.
- SAVE_REQ→SAVE_WAIT always.
- SAVE_WAIT→ACK on `save_done`.
- ACK→ENTER on `ack_done`.
- ENTER→MGMT always.
- MGMT→IDLE on `resume`.

Top module: `mgmt_irq_seq`

## Requirements
- R1: While `rst_n` is low, `save_req`, `ack_req`, `redirect`, `mm_active` and `out_hiz` are all 0.
- R2: `req_n_async` is active low and passes through a two-stage synchronizer. A request that is low across a single rising clock edge is still captured.
- R3: Number the first rising edge at which `req_n_async` is low as edge 0. A high `rsp_strobe` sampled at edge 8 or later accepts the request: `save_req` is 1 in the cycle that follows that edge. A strobe sampled at edge 7 or earlier does not accept it.
- R4: A request that misses the window stays pending, even if `req_n_async` returns high. It is accepted by a later strobe that meets the rule in R3.
- R5: On acceptance, `save_req` is high for exactly one cycle. `ack_req` stays low until `save_done` has been sampled high.
- R6: From the cycle after `save_done` is sampled high, `ack_req` is held high until `ack_done` is sampled high. `redirect` stays low during this time.
- R7: In the cycle after `ack_done` is sampled high, `redirect` is 1 for one cycle. `mm_active` is 1 from that cycle on.
- R8: From acceptance until the return to idle, new request assertions and strobes are ignored. A request that is still held low when `resume` arrives is not accepted afterwards.
- R9: `mm_active` stays 1 until `resume` is sampled high in management mode, and it is 0 in the following cycle.
- R10: At the first rising edge after `rst_n` rises, `out_hiz` takes the synchronized request level (1 = request active). A 1 stays until `rst_n` goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_async | input | 1 | Asynchronous active-low management interrupt request |
| rsp_strobe | input | 1 | Response status observed for the current transaction |
| save_done | input | 1 | Core reports the state save complete |
| ack_done | input | 1 | Acknowledge bus transaction complete |
| resume | input | 1 | Exit from management mode |
| save_req | output | 1 | One-cycle state-save request |
| ack_req | output | 1 | Acknowledge transaction request, held until done |
| redirect | output | 1 | One-cycle redirect to the handler |
| mm_active | output | 1 | Management mode in effect |
| out_hiz | output | 1 | Output high-impedance enable, set at reset release |

## Verification
The acceptance rule is tried with three request shapes, each against strobes placed at chosen edges:
- A request held low, with the strobe at exactly edge 8. This pins the sum of synchronizer latency and window length.
- A request whose strobe lands at edge 7 and which is then released. This separates a latched pending request from one that follows the input level.
- A request that is low for only a single edge. This shows that capture does not depend on how long the input stays low.

Requests and strobes driven during management mode, and across the resume pulse, tell apart a sequencer that ignores them from one that re-arms on the held level. Reset is released twice, once with the request active and once inactive, to show that the high-impedance enable follows the level at release and stays latched.

// File: rtl/mgmt_irq_pkg.sv
`timescale 1ns/1ps
package mgmt_irq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_REQ,
        ST_SAVE_WAIT,
        ST_ACK,
        ST_ENTER,
        ST_MGMT
    } seq_state_t;
endpackage

// File: rtl/mirq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer; stores the request as active-high so the
// power-up value of the stages reads as "no request".
module mirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req_n_async,
    output logic req_lvl
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        pipe <= {pipe[STAGES-2:0], ~req_n_async};
    end

    assign req_lvl = pipe[STAGES-1];
endmodule

// File: rtl/mirq_window.sv
`timescale 1ns/1ps
// Pending latch plus saturating age counter for the acceptance window.
module mirq_window #(
    parameter int THRESH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_lvl,
    input  logic arm,
    input  logic take,
    output logic ripe
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] CMAX = CW'(THRESH);

    logic          lvl_d;
    logic          pend_q;
    logic [CW-1:0] age_q;
    logic          new_edge;

    assign new_edge = req_lvl && !lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_d  <= 1'b0;
            pend_q <= 1'b0;
            age_q  <= '0;
        end else begin
            lvl_d <= req_lvl;
            if (take) begin
                pend_q <= 1'b0;
                age_q  <= '0;
            end else if (!pend_q && arm && new_edge) begin
                pend_q <= 1'b1;
                age_q  <= CW'(1);
            end else if (pend_q && age_q != CMAX) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign ripe = pend_q && (age_q == CMAX);
endmodule

// File: rtl/mirq_strap.sv
`timescale 1ns/1ps
// Samples the synchronized request once, at the first edge after reset release.
module mirq_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic req_lvl,
    output logic hiz
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            hiz     <= 1'b0;
        end else if (armed_q) begin
            armed_q <= 1'b0;
            hiz     <= req_lvl;
        end
    end
endmodule

// File: rtl/mgmt_irq_seq.sv
`timescale 1ns/1ps
module mgmt_irq_seq
    import mgmt_irq_pkg::*;
#(
    parameter int WINDOW_CLKS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    input  logic rsp_strobe,
    input  logic save_done,
    input  logic ack_done,
    input  logic resume,
    output logic save_req,
    output logic ack_req,
    output logic redirect,
    output logic mm_active,
    output logic out_hiz
);
    // synchronizer latency is spent inside the window
    localparam int THRESH = WINDOW_CLKS - SYNC_STAGES;

    seq_state_t state_q, state_d;
    logic req_lvl;
    logic ripe;
    logic accept;

    mirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .req_n_async(req_n_async),
        .req_lvl    (req_lvl)
    );

    mirq_window #(.THRESH(THRESH)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_lvl(req_lvl),
        .arm    (state_q == ST_IDLE),
        .take   (accept),
        .ripe   (ripe)
    );

    mirq_strap u_strap (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_lvl(req_lvl),
        .hiz    (out_hiz)
    );

    assign accept = (state_q == ST_IDLE) && ripe && rsp_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept)    state_d = ST_SAVE_REQ;
            ST_SAVE_REQ:                 state_d = ST_SAVE_WAIT;
            ST_SAVE_WAIT: if (save_done) state_d = ST_ACK;
            ST_ACK:       if (ack_done)  state_d = ST_ENTER;
            ST_ENTER:                    state_d = ST_MGMT;
            ST_MGMT:      if (resume)    state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        save_req  = 1'b0;
        ack_req   = 1'b0;
        redirect  = 1'b0;
        mm_active = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_SAVE_REQ:  save_req = 1'b1;
            ST_SAVE_WAIT: ;
            ST_ACK:       ack_req = 1'b1;
            ST_ENTER: begin
                redirect  = 1'b1;
                mm_active = 1'b1;
            end
            ST_MGMT:      mm_active = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/mgmt_irq_seq_chk.sv
`timescale 1ns/1ps
module mgmt_irq_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rsp_strobe,
    input logic save_done,
    input logic ack_done,
    input logic resume,
    input logic save_req,
    input logic ack_req,
    input logic redirect,
    input logic mm_active,
    input logic out_hiz
);
    p_accept_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_req) |-> $past(rsp_strobe));

    p_save_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> !save_req);

    p_ack_after_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(save_done));

    p_redirect_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect) |-> $past(ack_req && ack_done));

    p_redirect_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!redirect && mm_active));

    p_phase_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, ack_req, redirect}));

    p_no_reentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mm_active |=> !save_req);

    p_mm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_active && !resume) |=> mm_active);

    p_mm_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_active && !redirect && resume) |=> !mm_active);

    p_hiz_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz |=> out_hiz);
endmodule

bind mgmt_irq_seq mgmt_irq_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_strobe(rsp_strobe),
    .save_done (save_done),
    .ack_done  (ack_done),
    .resume    (resume),
    .save_req  (save_req),
    .ack_req   (ack_req),
    .redirect  (redirect),
    .mm_active (mm_active),
    .out_hiz   (out_hiz)
);

// File: tb/tb_mgmt_irq_seq.sv
`timescale 1ns/1ps
module tb_mgmt_irq_seq;
    logic clk = 1'b0;
    logic rst_n, req_n_async, rsp_strobe, save_done, ack_done, resume;
    logic save_req, ack_req, redirect, mm_active, out_hiz;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int exp_save[$];
    int exp_ent[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mgmt_irq_seq dut (
        .clk(clk), .rst_n(rst_n), .req_n_async(req_n_async),
        .rsp_strobe(rsp_strobe), .save_done(save_done), .ack_done(ack_done),
        .resume(resume), .save_req(save_req), .ack_req(ack_req),
        .redirect(redirect), .mm_active(mm_active), .out_hiz(out_hiz)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // driver: a strobe that should accept pushes the cycle of the save pulse
    task automatic strobe_now(input bit expect_accept);
        rsp_strobe = 1'b1;
        if (expect_accept) exp_save.push_back(cyc + 1);
        step();
        rsp_strobe = 1'b0;
    endtask

    // called in the cycle where save_req is visible
    task automatic finish_entry();
        step();
        chk("R5 save_req one cycle", save_req, 0);
        chk("R5 no ack before save_done", ack_req, 0);
        save_done = 1'b1;
        step();
        save_done = 1'b0;
        chk("R6 ack_req raised", ack_req, 1);
        chk("R6 no redirect during ack", redirect, 0);
        step(3);
        chk("R6 ack_req held", ack_req, 1);
        ack_done = 1'b1;
        exp_ent.push_back(cyc + 1);
        step();
        ack_done = 1'b0;
        chk("R7 mm_active at entry", mm_active, 1);
        step();
        chk("R7 redirect one cycle", redirect, 0);
        chk("R7 mm_active held", mm_active, 1);
    endtask

    task automatic do_resume();
        resume = 1'b1;
        step();
        resume = 1'b0;
        chk("R9 mm_active cleared after resume", mm_active, 0);
    endtask

    // monitor: pops expected events as the design produces them
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (save_req) begin
                if (exp_save.size() == 0) chk("R3/R8 unexpected save_req cycle", cyc, -1);
                else chk("R3/R4 save_req cycle", cyc, exp_save.pop_front());
            end
            if (redirect) begin
                if (exp_ent.size() == 0) chk("R7 unexpected redirect cycle", cyc, -1);
                else chk("R7 redirect cycle", cyc, exp_ent.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..R10 actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_n_async = 1'b1; rsp_strobe = 1'b0;
        save_done = 1'b0; ack_done = 1'b0; resume = 1'b0;
        step(4);
        // R1 reset state
        chk("R1 save_req", save_req, 0);
        chk("R1 ack_req", ack_req, 0);
        chk("R1 redirect", redirect, 0);
        chk("R1 mm_active", mm_active, 0);
        chk("R1 out_hiz", out_hiz, 0);
        rst_n = 1'b1;
        step(2);
        chk("R10 no strap when request idle", out_hiz, 0);

        // R3/R2: request held, strobe at edge 8 exactly
        req_n_async = 1'b0;
        step(8);
        strobe_now(1'b1);
        req_n_async = 1'b1;
        finish_entry();

        // R8: requests and strobes in management mode are ignored
        req_n_async = 1'b0;
        step(2);
        for (int i = 0; i < 4; i++) begin
            strobe_now(1'b0);
            step(2);
        end
        chk("R8 stays in management mode", mm_active, 1);
        do_resume();
        for (int i = 0; i < 3; i++) begin
            step(3);
            strobe_now(1'b0);
        end
        chk("R8 held request not taken after resume", save_req, 0);
        chk("R8 idle after resume", mm_active, 0);
        req_n_async = 1'b1;
        step(4);

        // R3 miss at edge 7, R4 pending after release
        req_n_async = 1'b0;
        step(7);
        strobe_now(1'b0);
        req_n_async = 1'b1;
        step(2);
        chk("R3 strobe at edge 7 not accepted", save_req, 0);
        step(3);
        strobe_now(1'b1);
        chk("R4 pending request accepted", save_req, 1);
        finish_entry();
        do_resume();
        step(4);

        // R2: single-edge pulse, strobe at edge 8
        req_n_async = 1'b0;
        step();
        req_n_async = 1'b1;
        step(7);
        strobe_now(1'b1);
        chk("R2 single-edge request captured", save_req, 1);
        finish_entry();
        do_resume();
        step(4);

        // R10: request active at reset release
        rst_n = 1'b0;
        req_n_async = 1'b0;
        step(4);
        chk("R1 out_hiz in reset", out_hiz, 0);
        rst_n = 1'b1;
        step(2);
        chk("R10 strap sets out_hiz", out_hiz, 1);
        req_n_async = 1'b1;
        step(6);
        chk("R10 out_hiz stays set", out_hiz, 1);
        rst_n = 1'b0;
        step();
        chk("R10 out_hiz cleared by reset", out_hiz, 0);
        step(3);
        rst_n = 1'b1;
        step(2);
        chk("R10 release with idle request", out_hiz, 0);

        chk("R3 all expected saves seen", exp_save.size(), 0);
        chk("R7 all expected redirects seen", exp_ent.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule